// File: doc/BRIEF.md
# Four-Address Memory-to-Memory Sequencer

This block is the control unit of a small machine that keeps no program counter. Every instruction occupies five consecutive memory words. In order, they hold the opcode, the result address, the address of the first operand, the address of the second operand, and the address of the instruction that follows. The sequencer drives a single-port synchronous memory of 24-bit words. It reads the five words, fetches both operands, applies the operation, stores the result and then moves to whatever address the link word names.

The block counts the memory accesses that go to fetching the instruction and those that go to executing it, and it reports both counts and their sum for every instruction. A start pulse loads the address of the first instruction from an input port. A halt opcode stops the machine. Any opcode the block does not know also stops it, and raises an illegal flag.

Top module: `quad_addr_seq`

## Requirements
- R1: After reset the block is idle. It issues no memory request, and `done_o`, `halted_o`, `illegal_o` and `busy_o` are low. All three count outputs are zero.
- R2: A `start_i` pulse taken while the block is idle or halted makes it issue a read to `entry_addr_i` in the next cycle. Reads to the four following addresses come in the next four cycles, one per cycle.
- R3: The five instruction words are, in order: opcode, result address, operand-1 address, operand-2 address and next-instruction address. The opcode is the low 8 bits of its word. The upper 16 bits of that word have no effect.
- R4: Opcode 0x01 writes M[op1] + M[op2] modulo 2^24 to M[result].
- R5: Opcode 0x02 writes M[op1] - M[op2] modulo 2^24 to M[result].
- R6: After the write-back, the next fetch starts at the next-instruction field. The address after the instruction's own five words is never fetched.
- R7: After each add or subtract, the outputs report fetch = 5, execute = 3 and total = 8.
- R8: `done_o` goes high for exactly one cycle after each write-back. It stays high for as long as the block is halted.
- R9: Opcode 0xFF halts the block without writing. It reports fetch = 5, execute = 0 and total = 5, and no further memory requests are issued.
- R10: Any other opcode sets `illegal_o` and halts the block with no write-back.
- R11: A `start_i` pulse while `busy_o` is high has no effect.
- R12: At most one access is issued per cycle. Read data is taken in the cycle after the read is issued. Execution reads operand 1, then operand 2, and then writes once.
- R13: A start from the halted state clears `illegal_o` and `halted_o` and runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only when idle or halted |
| entry_addr_i | input | AW | Address of the first instruction |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one cycle after the read |
| busy_o | output | 1 | Executing a program |
| done_o | output | 1 | Write-back pulse, or held high while halted |
| halted_o | output | 1 | Machine stopped |
| illegal_o | output | 1 | Stopped on an unknown opcode |
| fetch_cnt_o | output | CW | Fetch accesses of the last instruction |
| exec_cnt_o | output | CW | Execute accesses of the last instruction |
| total_cnt_o | output | CW | Sum of the two counts |

## Verification
The bench goes after the corners where a sequencer of this kind tends to slip:
- **Wrap-around.** Add and subtract results that wrap past 2^24. A design that widened or saturated the result would store the wrong word.
- **Link word ignored.** A design that stepped past the instruction instead of following the link word would read the address after the instruction's five words.
- **Dirty opcode word.** An opcode word with junk in its upper bits would be treated as illegal if the decode looked at the full word.
- **Unknown opcode.** The bench checks that the result location keeps its sentinel value, since a wrong design might write it anyway.
- **Halt counts.** A halt opcode must report five fetch accesses and no execute accesses.
- **Start while busy.** A start pulse during execution must not redirect the fetch.
- **Late read capture.** A design that captured read data a cycle late would pair the wrong words with the wrong fields.

// File: rtl/qas_pkg.sv
package qas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_RD_A, ST_RD_B, ST_CALC, ST_WRITE, ST_HALT
  } st_e;

  typedef enum logic [1:0] {TG_NONE, TG_FETCH, TG_OPA, TG_OPB} tag_e;

  localparam int unsigned INSTR_WORDS = 5;
  localparam int unsigned FLD_OPC  = 0;
  localparam int unsigned FLD_RES  = 1;
  localparam int unsigned FLD_OPA  = 2;
  localparam int unsigned FLD_OPB  = 3;
  localparam int unsigned FLD_LINK = 4;

  localparam logic [7:0] OPC_ADD  = 8'h01;
  localparam logic [7:0] OPC_SUB  = 8'h02;
  localparam logic [7:0] OPC_HALT = 8'hFF;
endpackage

// File: rtl/qas_tally.sv
module qas_tally #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] nxt_o
);
  always_comb begin
    if (clr) nxt_o = inc ? CW'(1) : '0;
    else     nxt_o = cnt_o + CW'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= nxt_o;
  end
endmodule

// File: rtl/qas_alu.sv
module qas_alu #(
  parameter int DW = 24
) (
  input  logic [7:0]    opc,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  import qas_pkg::*;

  always_comb begin
    case (opc)
      OPC_SUB: y = a - b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/quad_addr_seq.sv
module quad_addr_seq #(
  parameter int AW = 24,
  parameter int DW = 24,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] entry_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          halted_o,
  output logic          illegal_o,
  output logic [CW-1:0] fetch_cnt_o,
  output logic [CW-1:0] exec_cnt_o,
  output logic [CW-1:0] total_cnt_o
);
  import qas_pkg::*;

  localparam int IW = $clog2(INSTR_WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(INSTR_WORDS - 1);
  localparam int NCLS = 2;

  st_e           state_q;
  tag_e          tag_q, tag_d;
  logic [IW-1:0] fidx_q, tag_idx_q;
  logic [AW-1:0] base_q, res_q, opa_q, opb_q, link_q;
  logic [7:0]    opc_q;
  logic [DW-1:0] opa_val_q, result_q, alu_y;
  logic          done_q, halted_q, illegal_q;
  logic          is_arith, snap;
  logic [NCLS-1:0]   cls_inc;
  logic [CW-1:0]     cls_nxt [NCLS];

  assign is_arith = (opc_q == OPC_ADD) || (opc_q == OPC_SUB);

  // Memory access decode: one access per cycle, driven from state
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    tag_d       = TG_NONE;
    case (state_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base_q + AW'(fidx_q);
        tag_d      = TG_FETCH;
      end
      ST_RD_A: begin
        mem_req_o  = 1'b1;
        mem_addr_o = opa_q;
        tag_d      = TG_OPA;
      end
      ST_RD_B: begin
        mem_req_o  = 1'b1;
        mem_addr_o = opb_q;
        tag_d      = TG_OPB;
      end
      ST_WRITE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = res_q;
        mem_wdata_o = result_q;
      end
      default: ;
    endcase
  end

  qas_alu #(.DW(DW)) u_alu (
    .opc (opc_q),
    .a   (opa_val_q),
    .b   (mem_rdata_i),
    .y   (alu_y)
  );

  // Control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      fidx_q    <= '0;
      base_q    <= '0;
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= (state_q == ST_WRITE);
      case (state_q)
        ST_IDLE, ST_HALT: begin
          if (start_i) begin
            state_q   <= ST_FETCH;
            base_q    <= entry_addr_i;
            fidx_q    <= '0;
            halted_q  <= 1'b0;
            illegal_q <= 1'b0;
          end
        end
        ST_FETCH: begin
          fidx_q <= fidx_q + 1'b1;
          if (fidx_q == LAST_IDX) state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (is_arith) begin
            state_q <= ST_RD_A;
          end else begin
            state_q   <= ST_HALT;
            halted_q  <= 1'b1;
            illegal_q <= (opc_q != OPC_HALT);
          end
        end
        ST_RD_A: state_q <= ST_RD_B;
        ST_RD_B: state_q <= ST_CALC;
        ST_CALC: state_q <= ST_WRITE;
        ST_WRITE: begin
          state_q <= ST_FETCH;
          base_q  <= link_q;
          fidx_q  <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Capture of returning read data, one cycle after issue
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q     <= TG_NONE;
      tag_idx_q <= '0;
      opc_q     <= '0;
      res_q     <= '0;
      opa_q     <= '0;
      opb_q     <= '0;
      link_q    <= '0;
      opa_val_q <= '0;
      result_q  <= '0;
    end else begin
      tag_q     <= tag_d;
      tag_idx_q <= fidx_q;
      case (tag_q)
        TG_FETCH: begin
          case (tag_idx_q)
            IW'(FLD_OPC):  opc_q  <= mem_rdata_i[7:0];
            IW'(FLD_RES):  res_q  <= mem_rdata_i[AW-1:0];
            IW'(FLD_OPA):  opa_q  <= mem_rdata_i[AW-1:0];
            IW'(FLD_OPB):  opb_q  <= mem_rdata_i[AW-1:0];
            IW'(FLD_LINK): link_q <= mem_rdata_i[AW-1:0];
            default: ;
          endcase
        end
        TG_OPA: opa_val_q <= mem_rdata_i;
        TG_OPB: result_q  <= alu_y;
        default: ;
      endcase
    end
  end

  // Access tallies: class 0 = fetch, class 1 = execute
  assign cls_inc[0] = mem_req_o && (state_q == ST_FETCH);
  assign cls_inc[1] = mem_req_o && (state_q != ST_FETCH);

  generate
    for (genvar g = 0; g < NCLS; g++) begin : g_tally
      logic [CW-1:0] cnt_unused;
      qas_tally #(.CW(CW)) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clr   ((state_q == ST_FETCH) && (fidx_q == '0)),
        .inc   (cls_inc[g]),
        .cnt_o (cnt_unused),
        .nxt_o (cls_nxt[g])
      );
    end
  endgenerate

  assign snap = (state_q == ST_WRITE) || ((state_q == ST_DECODE) && !is_arith);

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_cnt_o <= '0;
      exec_cnt_o  <= '0;
      total_cnt_o <= '0;
    end else if (snap) begin
      fetch_cnt_o <= cls_nxt[0];
      exec_cnt_o  <= cls_nxt[1];
      total_cnt_o <= cls_nxt[0] + cls_nxt[1];
    end
  end

  assign busy_o    = (state_q != ST_IDLE) && (state_q != ST_HALT);
  assign done_o    = done_q | halted_q;
  assign halted_o  = halted_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/qas_checker.sv
module qas_checker #(
  parameter int AW = 24,
  parameter int DW = 24,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [AW-1:0] entry_addr_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          halted_o,
  input logic          illegal_o,
  input logic [CW-1:0] fetch_cnt_o,
  input logic [CW-1:0] exec_cnt_o,
  input logic [CW-1:0] total_cnt_o
);
  p_we_has_req_r12: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> mem_req_o);

  p_start_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(entry_addr_i)));

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> (!mem_req_o && done_o && !busy_o));

  p_illegal_halts_r10: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> halted_o);

  p_counts_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !halted_o) |-> (fetch_cnt_o == CW'(5) && exec_cnt_o == CW'(3)
                               && total_cnt_o == CW'(8)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !halted_o) |=> !done_o);
endmodule

bind quad_addr_seq qas_checker #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .entry_addr_i (entry_addr_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .halted_o     (halted_o),
  .illegal_o    (illegal_o),
  .fetch_cnt_o  (fetch_cnt_o),
  .exec_cnt_o   (exec_cnt_o),
  .total_cnt_o  (total_cnt_o)
);

// File: tb/sim_quad_addr_seq.sv
`timescale 1ns/1ps
module sim_quad_addr_seq;
  localparam int AW = 24;
  localparam int DW = 24;
  localparam int CW = 4;
  localparam int NV = 6;
  localparam logic [23:0] INS = 24'd8;
  localparam logic [23:0] HLT = 24'd100;
  localparam logic [23:0] SENT = 24'h5A5A5A;
  // {opcode word, operand 1, operand 2, expected result}
  localparam logic [23:0] VEC [NV][4] = '{
    '{24'h000001, 24'd1,      24'd2, 24'd3},
    '{24'h000001, 24'hFFFFFF, 24'd2, 24'd1},
    '{24'h000002, 24'd10,     24'd3, 24'd7},
    '{24'h000002, 24'd5,      24'd7, 24'hFFFFFE},
    '{24'hABCD01, 24'd100,    24'd23, 24'd123},
    '{24'h7F3302, 24'h800000, 24'd1, 24'h7FFFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] entry_addr_i = '0;
  logic mem_req_o, mem_we_o, busy_o, done_o, halted_o, illegal_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic [CW-1:0] fetch_cnt_o, exec_cnt_o, total_cnt_o;

  logic [DW-1:0] mem [256];
  logic tb_ld = 1'b0;
  logic [7:0] tb_a = '0;
  logic [DW-1:0] tb_d = '0;

  int checks = 0;
  int failures = 0;
  int done_pulses = 0;
  int writes = 0;
  int past_reads = 0;
  int rd60 = 0;
  logic [CW-1:0] cap_f = '0, cap_e = '0, cap_t = '0;

  always #2.5 clk = ~clk;

  quad_addr_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (.*);

  always @(posedge clk) begin
    if (tb_ld) mem[tb_a] <= tb_d;
    else if (mem_req_o && mem_we_o) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o;
      writes <= writes + 1;
    end else if (mem_req_o) begin
      mem_rdata_i <= mem[mem_addr_o[7:0]];
      if (mem_addr_o >= INS + 24'd5 && mem_addr_o < INS + 24'd10) past_reads <= past_reads + 1;
      if (mem_addr_o == 24'd60) rd60 <= rd60 + 1;
    end
  end

  always @(negedge clk) begin
    if (done_o && !halted_o) begin
      done_pulses <= done_pulses + 1;
      cap_f <= fetch_cnt_o;
      cap_e <= exec_cnt_o;
      cap_t <= total_cnt_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk); tb_ld = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk); tb_ld = 1'b0;
  endtask

  task automatic load_instr(input logic [23:0] opw, input logic [23:0] a, input logic [23:0] b);
    poke(INS[7:0], opw);
    poke(INS[7:0] + 8'd1, 24'd42);
    poke(INS[7:0] + 8'd2, 24'd40);
    poke(INS[7:0] + 8'd3, 24'd41);
    poke(INS[7:0] + 8'd4, HLT);
    poke(8'd40, a);
    poke(8'd41, b);
    poke(8'd42, SENT);
  endtask

  task automatic pulse_start(input logic [23:0] ea);
    @(negedge clk); start_i = 1'b1; entry_addr_i = ea;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_halt();
    int n = 0;
    @(negedge clk);
    while (!halted_o && n < 400) begin @(negedge clk); n++; end
    check("R9 halt reached", {31'd0, halted_o}, 32'd1);
  endtask

  initial begin
    #(5ns * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int dp0, pr0, wr0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[HLT[7:0]] = 24'h0000FF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 req", {31'd0, mem_req_o}, 0);
    check("R1 flags", {28'd0, busy_o, done_o, halted_o, illegal_o}, 0);
    check("R1 counts", {20'd0, fetch_cnt_o, exec_cnt_o, total_cnt_o}, 0);

    // R2 fetch order and timing
    load_instr(VEC[0][0], VEC[0][1], VEC[0][2]);
    @(negedge clk); start_i = 1'b1; entry_addr_i = INS;
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check("R2 fetch addr", {mem_req_o, 7'd0, mem_addr_o}, {1'b1, 7'd0, INS + 24'(k)});
      @(negedge clk);
    end
    wait_halt();

    // Table of vectors: R3 R4 R5 R6 R7 R8 R13
    for (int v = 0; v < NV; v++) begin
      load_instr(VEC[v][0], VEC[v][1], VEC[v][2]);
      dp0 = done_pulses; pr0 = past_reads;
      pulse_start(INS);
      check("R13 restart clears halt", {31'd0, halted_o}, 0);
      wait_halt();
      check("R3/R4/R5 result", {8'd0, mem[42]}, {8'd0, VEC[v][3]});
      check("R7 fetch", {28'd0, cap_f}, 5);
      check("R7 exec", {28'd0, cap_e}, 3);
      check("R7 total", {28'd0, cap_t}, 8);
      check("R8 one done pulse", done_pulses - dp0, 1);
      check("R6 link followed", past_reads - pr0, 0);
      check("R9 halt counts", {20'd0, fetch_cnt_o, exec_cnt_o, total_cnt_o}, {20'd0, 4'd5, 4'd0, 4'd5});
      check("R8 done held", {31'd0, done_o}, 1);
    end

    // R10 illegal opcode, no write
    load_instr(24'h000007, 24'd1, 24'd1);
    wr0 = writes;
    pulse_start(INS);
    wait_halt();
    check("R10 illegal flag", {31'd0, illegal_o}, 1);
    check("R10 no write", writes - wr0, 0);
    check("R10 result untouched", {8'd0, mem[42]}, {8'd0, SENT});

    // R13 restart after illegal, R11 start while busy ignored
    load_instr(24'h000001, 24'd20, 24'd22);
    pulse_start(INS);
    check("R13 illegal cleared", {31'd0, illegal_o}, 0);
    repeat (3) @(negedge clk);
    check("R11 busy", {31'd0, busy_o}, 1);
    pulse_start(24'd60);
    wait_halt();
    check("R11 no redirect", rd60, 0);
    check("R11 result", {8'd0, mem[42]}, 32'd42);

    // R9 direct halt: no write, no done pulse
    wr0 = writes; dp0 = done_pulses;
    pulse_start(HLT);
    wait_halt();
    check("R9 counts", {20'd0, fetch_cnt_o, exec_cnt_o, total_cnt_o}, {20'd0, 4'd5, 4'd0, 4'd5});
    check("R9 no write", writes - wr0, 0);
    check("R9 no pulse", done_pulses - dp0, 0);
    repeat (3) @(negedge clk);
    check("R9 quiet", {31'd0, mem_req_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule